// File: doc/BRIEF.md
# Extended Register Window Access Decoder

This block sits between an instruction-level register access port and the register bank of a per-core interrupt controller. Every request that lands in the 256-entry extended register window is judged against the rule of the register it addresses. The request then gets exactly one outcome: a fault, a read whose data has its reserved positions cleared, or a write strobe to a single named register that carries the cleaned write data.

Requests outside the window are not answered. Each answered request produces a registered response one clock after it is presented. The register bank supplies read data for the presented address in the same cycle. The controller's mode input decides whether the window is reachable at all. Only the extended mode opens it.

Top module: `xrd_access_decoder`

## Requirements
- R1: A request whose address lies in 0x800..0x8FF produces a response (`rsp_valid` high) in the cycle after it is presented. A request outside that range, or no request, leaves `rsp_valid` low.
- R2: Any window request while `ctl_mode` is not 2 (0 = disabled, 1 = legacy, 2 = extended, 3 = invalid) faults.
- R3: Offsets 0x0E, 0x31 and every offset that is not a defined register fault on both read and write.
- R4: A write to a read-only register faults. The read-only registers are ID 0x02, version 0x03, processor priority 0x0A, logical destination 0x0D, the three 256-bit vector banks at 0x10..0x27, and current count 0x39.
- R5: A read of the end-of-interrupt register (0x0B) or the self-interrupt register (0x3F) faults.
- R6: A write of any non-zero value to end-of-interrupt (0x0B) or error status (0x28) faults. A zero write strobes the register.
- R7: A write that sets a reserved bit faults. Bits 63..32 are reserved everywhere except the command register. The writable bits are:
  - task priority: bits 7..0;
  - spurious vector: bits 8..0 and 12;
  - self-interrupt: bits 7..0;
  - each vector-table entry (0x32..0x37): mask 0x0003_17FF;
  - timer divide (0x3E): mask 0xB;
  - timer initial count (0x38): bits 31..0.
- R8: The command register (0x30) accepts a full 64-bit write. Bit 12 of the forwarded write data is forced to zero and never causes a fault.
- R9: Read data keeps only the bits the register defines. Bits 63..32 are zero for every register except the command register. The defined read masks are:
  - version: 0x00FF_00FF;
  - task priority and processor priority: 0xFF;
  - spurious vector: 0x11FF;
  - error status: 0xFF;
  - vector-table entries: 0x0003_17FF;
  - timer divide: 0xB;
  - all other readable registers: 32 bits.
- R10: A faulted response has `rsp_wr_en` zero and `rsp_rdata` zero. A successful read has `rsp_wr_en` zero. `rsp_wr_en` is never more than one-hot.
- R11: A successful write raises exactly one enable bit:
  - bit 0: task priority;
  - bit 1: end-of-interrupt;
  - bit 2: spurious vector;
  - bit 3: error status;
  - bit 4: command;
  - bit 5: self-interrupt;
  - bit 6: timer initial count;
  - bit 7: timer divide;
  - bits 8..13: vector-table entries 0x32..0x37 in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Register address |
| req_wdata | input | 64 | Write data |
| ctl_mode | input | 2 | Controller mode: 0 disabled, 1 legacy, 2 extended |
| bank_rdata | input | 64 | Raw read data from the register bank for `req_addr` |
| rsp_valid | output | 1 | Response for last cycle's window request |
| rsp_fault | output | 1 | Request violated its register's rule |
| rsp_rdata | output | 64 | Masked read data, zero on writes and faults |
| rsp_wr_en | output | 14 | One-hot write strobe, indices per R11 |
| rsp_wr_data | output | 64 | Cleaned write data accompanying the strobe |

## Verification
The assertions check the following on every cycle:
- the response timing and window membership;
- the blanket mode fault;
- a fault on any end-of-interrupt read or non-zero end-of-interrupt write;
- the fault-implies-no-strobe-and-no-data rule;
- the one-hot strobe;
- the zero upper half on every non-command response.

Only the directed scenarios can show the per-register mask values, the exact strobe index chosen for each register, the command register's bit-12 clearing, and the distinction between read-only, write-only and reserved offsets. Those depend on the address table, which a generic property does not restate.

// File: rtl/xrd_pkg.sv
package xrd_pkg;
   localparam int unsigned DATA_W   = 64;
   localparam int unsigned NUM_WE   = 14;
   localparam int unsigned WE_IDX_W = $clog2(NUM_WE);

   typedef enum logic [1:0] {
      MODE_OFF    = 2'd0,
      MODE_LEGACY = 2'd1,
      MODE_EXT    = 2'd2,
      MODE_BAD    = 2'd3
   } xrd_mode_e;

   typedef enum logic [WE_IDX_W-1:0] {
      WE_TPRI  = 4'd0,
      WE_EOI   = 4'd1,
      WE_SPUR  = 4'd2,
      WE_ERR   = 4'd3,
      WE_CMD   = 4'd4,
      WE_SELF  = 4'd5,
      WE_TINIT = 4'd6,
      WE_TDIV  = 4'd7,
      WE_LVT0  = 4'd8
   } xrd_we_e;

   typedef struct packed {
      logic                  rd_ok;
      logic                  wr_ok;
      logic [DATA_W-1:0]     rd_mask;
      logic [DATA_W-1:0]     wr_mask;
      logic [DATA_W-1:0]     ign_mask;
      logic [WE_IDX_W-1:0]   wr_idx;
   } xrd_rule_t;

   localparam logic [DATA_W-1:0] M_LO32 = 64'h0000_0000_FFFF_FFFF;
   localparam logic [DATA_W-1:0] M_ALL  = '1;
   localparam logic [DATA_W-1:0] M_LVT  = 64'h0000_0000_0003_17FF;
endpackage

// File: rtl/xrd_offset_decode.sv
module xrd_offset_decode
   import xrd_pkg::*;
#(
   parameter int unsigned LVT_N    = 6,
   parameter logic [7:0]  LVT_BASE = 8'h32
) (
   input  logic [7:0] off,
   output xrd_rule_t  rule
);
   localparam int unsigned LVT_LAST = LVT_BASE + LVT_N - 1;

   if (LVT_N < 1 || LVT_LAST > 8'h37) begin : g_bad_lvt
      $error("xrd_offset_decode: vector-table span out of range");
   end

   logic [LVT_N-1:0] lvt_hit;
   for (genvar gi = 0; gi < LVT_N; gi++) begin : g_lvt
      assign lvt_hit[gi] = (off == 8'(LVT_BASE + gi));
   end

   function automatic xrd_rule_t mk(logic r, logic w, logic [DATA_W-1:0] rm,
                                    logic [DATA_W-1:0] wm, logic [WE_IDX_W-1:0] ix);
      xrd_rule_t t;
      t.rd_ok    = r;
      t.wr_ok    = w;
      t.rd_mask  = rm;
      t.wr_mask  = wm;
      t.ign_mask = '0;
      t.wr_idx   = ix;
      return t;
   endfunction

   always_comb begin
      rule = mk(1'b0, 1'b0, '0, '0, '0);
      unique case (off)
         8'h02: rule = mk(1'b1, 1'b0, M_LO32, '0, '0);
         8'h03: rule = mk(1'b1, 1'b0, 64'h00FF_00FF, '0, '0);
         8'h08: rule = mk(1'b1, 1'b1, 64'hFF, 64'hFF, WE_TPRI);
         8'h0A: rule = mk(1'b1, 1'b0, 64'hFF, '0, '0);
         8'h0B: rule = mk(1'b0, 1'b1, '0, '0, WE_EOI);
         8'h0D: rule = mk(1'b1, 1'b0, M_LO32, '0, '0);
         8'h0F: rule = mk(1'b1, 1'b1, 64'h11FF, 64'h11FF, WE_SPUR);
         8'h28: rule = mk(1'b1, 1'b1, 64'hFF, '0, WE_ERR);
         8'h30: begin
            rule = mk(1'b1, 1'b1, M_ALL, M_ALL, WE_CMD);
            rule.ign_mask = 64'h1000;
         end
         8'h38: rule = mk(1'b1, 1'b1, M_LO32, M_LO32, WE_TINIT);
         8'h39: rule = mk(1'b1, 1'b0, M_LO32, '0, '0);
         8'h3E: rule = mk(1'b1, 1'b1, 64'hB, 64'hB, WE_TDIV);
         8'h3F: rule = mk(1'b0, 1'b1, '0, 64'hFF, WE_SELF);
         default: ;
      endcase
      if (off >= 8'h10 && off <= 8'h27)
         rule = mk(1'b1, 1'b0, M_LO32, '0, '0);
      for (int i = 0; i < LVT_N; i++)
         if (lvt_hit[i])
            rule = mk(1'b1, 1'b1, M_LVT, M_LVT, WE_IDX_W'(WE_LVT0 + i));
   end
endmodule

// File: rtl/xrd_rule_check.sv
module xrd_rule_check
   import xrd_pkg::*;
(
   input  xrd_rule_t           rule,
   input  logic                is_write,
   input  logic                mode_ok,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [DATA_W-1:0]   raw_rdata,
   output logic                fault,
   output logic [NUM_WE-1:0]   we,
   output logic [DATA_W-1:0]   wdata_clean,
   output logic [DATA_W-1:0]   rdata_clean
);
   logic bad_bits;
   assign bad_bits = |(wdata & ~(rule.wr_mask | rule.ign_mask));

   always_comb begin
      fault = !mode_ok;
      if (is_write) fault = fault | !rule.wr_ok | bad_bits;
      else          fault = fault | !rule.rd_ok;
   end

   always_comb begin
      we = '0;
      if (is_write && !fault) we[rule.wr_idx] = 1'b1;
   end

   assign wdata_clean = (is_write && !fault) ? (wdata & rule.wr_mask & ~rule.ign_mask) : '0;
   assign rdata_clean = (!is_write && !fault) ? (raw_rdata & rule.rd_mask) : '0;
endmodule

// File: rtl/xrd_access_decoder.sv
module xrd_access_decoder
   import xrd_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter logic [31:0] WIN_BASE = 32'h0000_0800,
   parameter int unsigned LVT_N    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [31:0]       req_addr,
   input  logic [63:0]       req_wdata,
   input  logic [1:0]        ctl_mode,
   input  logic [63:0]       bank_rdata,
   output logic              rsp_valid,
   output logic              rsp_fault,
   output logic [63:0]       rsp_rdata,
   output logic [13:0]       rsp_wr_en,
   output logic [63:0]       rsp_wr_data
);
   localparam int unsigned OFF_W = 8;

   if (ADDR_W != 32 || WIN_BASE[OFF_W-1:0] != '0) begin : g_bad_cfg
      $error("xrd_access_decoder: window base must be 256-aligned in a 32-bit space");
   end

   logic      in_win;
   xrd_rule_t rule;
   logic      c_fault;
   logic [NUM_WE-1:0] c_we;
   logic [DATA_W-1:0] c_wd, c_rd;

   assign in_win = req_valid && (req_addr[ADDR_W-1:OFF_W] == WIN_BASE[ADDR_W-1:OFF_W]);

   xrd_offset_decode #(.LVT_N(LVT_N)) u_dec (
      .off  (req_addr[OFF_W-1:0]),
      .rule (rule)
   );

   xrd_rule_check u_chk (
      .rule        (rule),
      .is_write    (req_write),
      .mode_ok     (ctl_mode == MODE_EXT),
      .wdata       (req_wdata),
      .raw_rdata   (bank_rdata),
      .fault       (c_fault),
      .we          (c_we),
      .wdata_clean (c_wd),
      .rdata_clean (c_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_fault   <= 1'b0;
         rsp_rdata   <= '0;
         rsp_wr_en   <= '0;
         rsp_wr_data <= '0;
      end else begin
         rsp_valid   <= in_win;
         rsp_fault   <= in_win && c_fault;
         rsp_rdata   <= in_win ? c_rd : '0;
         rsp_wr_en   <= in_win ? c_we : '0;
         rsp_wr_data <= in_win ? c_wd : '0;
      end
   end
endmodule

// File: rtl/xrd_access_decoder_chk.sv
module xrd_access_decoder_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_write,
   input logic [31:0] req_addr,
   input logic [63:0] req_wdata,
   input logic [1:0]  ctl_mode,
   input logic        rsp_valid,
   input logic        rsp_fault,
   input logic [63:0] rsp_rdata,
   input logic [13:0] rsp_wr_en
);
   logic hit;
   assign hit = req_valid && (req_addr[31:8] == 24'h000008);

   // R1
   window_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> rsp_valid);
   // R1
   no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> !rsp_valid);
   // R2
   mode_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && ctl_mode != 2'd2) |=> rsp_fault);
   // R5
   eoi_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !req_write && req_addr[7:0] == 8'h0B) |=> rsp_fault);
   // R6
   eoi_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && req_write && req_addr[7:0] == 8'h0B && req_wdata != 64'd0) |=> rsp_fault);
   // R10
   fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_wr_en == 14'd0 && rsp_rdata == 64'd0));
   // R10
   onehot_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rsp_wr_en));
   // R9
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && req_addr[7:0] != 8'h30) |=> rsp_rdata[63:32] == 32'd0);
endmodule

bind xrd_access_decoder xrd_access_decoder_chk u_xrd_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .req_wdata (req_wdata),
   .ctl_mode  (ctl_mode),
   .rsp_valid (rsp_valid),
   .rsp_fault (rsp_fault),
   .rsp_rdata (rsp_rdata),
   .rsp_wr_en (rsp_wr_en)
);

// File: tb/xrd_access_decoder_tb.sv
module xrd_access_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [63:0] req_wdata = '0;
   logic [1:0]  ctl_mode = 2'd2;
   logic [63:0] bank_rdata;
   logic [63:0] bank_val = '1;
   logic        rsp_valid, rsp_fault;
   logic [63:0] rsp_rdata, rsp_wr_data;
   logic [13:0] rsp_wr_en;
   int n_run = 0;
   int n_fail = 0;

   assign bank_rdata = bank_val;
   always #5 clk = ~clk;

   xrd_access_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .ctl_mode(ctl_mode),
      .bank_rdata(bank_rdata), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
      .rsp_rdata(rsp_rdata), .rsp_wr_en(rsp_wr_en), .rsp_wr_data(rsp_wr_data)
   );

   task automatic issue(input logic w, input logic [31:0] a, input logic [63:0] d,
                        input logic [1:0] m);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; ctl_mode = m;
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic expect_rsp(input string tag, input logic v, input logic f,
                             input logic [13:0] we, input logic [63:0] wd,
                             input logic [63:0] rd);
      n_run++;
      if (rsp_valid !== v || rsp_fault !== f || rsp_wr_en !== we ||
          rsp_wr_data !== wd || rsp_rdata !== rd) begin
         n_fail++;
         $display("FAIL %s: got v=%b f=%b we=%h wd=%h rd=%h exp v=%b f=%b we=%h wd=%h rd=%h",
                  tag, rsp_valid, rsp_fault, rsp_wr_en, rsp_wr_data, rsp_rdata,
                  v, f, we, wd, rd);
      end
   endtask

   task automatic rd_ok(string tag, logic [7:0] off, logic [63:0] exp);
      issue(1'b0, 32'h800 + off, '0, 2'd2);
      expect_rsp(tag, 1, 0, '0, '0, exp);
   endtask
   task automatic wr_ok(string tag, logic [7:0] off, logic [63:0] d, int idx, logic [63:0] expd);
      issue(1'b1, 32'h800 + off, d, 2'd2);
      expect_rsp(tag, 1, 0, 14'(1) << idx, expd, '0);
   endtask
   task automatic flt(string tag, logic w, logic [7:0] off, logic [63:0] d, logic [1:0] m);
      issue(w, 32'h800 + off, d, m);
      expect_rsp(tag, 1, 1, '0, '0, '0);
   endtask

   task automatic t_reset;
      expect_rsp("R1 reset state", 0, 0, '0, '0, '0);
   endtask

   task automatic t_window;
      issue(1'b0, 32'h7FF, '0, 2'd2);
      expect_rsp("R1 below window", 0, 0, '0, '0, '0);
      issue(1'b1, 32'h900, 64'h1, 2'd2);
      expect_rsp("R1 above window", 0, 0, '0, '0, '0);
      @(negedge clk); #1;
      expect_rsp("R1 idle", 0, 0, '0, '0, '0);
   endtask

   task automatic t_mode;
      flt("R2 legacy read", 1'b0, 8'h02, '0, 2'd1);
      flt("R2 disabled write", 1'b1, 8'h08, 64'h5, 2'd0);
      flt("R2 invalid mode", 1'b0, 8'h0F, '0, 2'd3);
   endtask

   task automatic t_reserved;
      flt("R3 0x0E read", 1'b0, 8'h0E, '0, 2'd2);
      flt("R3 0x31 write", 1'b1, 8'h31, '0, 2'd2);
      flt("R3 0x31 read", 1'b0, 8'h31, '0, 2'd2);
      flt("R3 0xFF read", 1'b0, 8'hFF, '0, 2'd2);
   endtask

   task automatic t_readonly;
      flt("R4 write ID", 1'b1, 8'h02, '0, 2'd2);
      flt("R4 write bank 0x1C", 1'b1, 8'h1C, '0, 2'd2);
      flt("R4 write current count", 1'b1, 8'h39, 64'h1, 2'd2);
      rd_ok("R4 read bank 0x27", 8'h27, 64'hFFFF_FFFF);
   endtask

   task automatic t_writeonly;
      flt("R5 read EOI", 1'b0, 8'h0B, '0, 2'd2);
      flt("R5 read self", 1'b0, 8'h3F, '0, 2'd2);
      wr_ok("R11 self write", 8'h3F, 64'h31, 5, 64'h31);
   endtask

   task automatic t_zero_only;
      flt("R6 EOI nonzero", 1'b1, 8'h0B, 64'h1, 2'd2);
      flt("R6 ESR nonzero", 1'b1, 8'h28, 64'h80, 2'd2);
      wr_ok("R6 EOI zero", 8'h0B, '0, 1, '0);
      wr_ok("R6 ESR zero", 8'h28, '0, 3, '0);
   endtask

   task automatic t_rsvd_bits;
      flt("R7 TPR bit8", 1'b1, 8'h08, 64'h100, 2'd2);
      flt("R7 SPUR bit9", 1'b1, 8'h0F, 64'h200, 2'd2);
      flt("R7 upper half", 1'b1, 8'h38, 64'h1_0000_0000, 2'd2);
      flt("R7 self bit8", 1'b1, 8'h3F, 64'h100, 2'd2);
      wr_ok("R7 SPUR legal", 8'h0F, 64'h11FF, 2, 64'h11FF);
      wr_ok("R7 TPR legal", 8'h08, 64'hA5, 0, 64'hA5);
   endtask

   task automatic t_cmd;
      wr_ok("R8 cmd 64-bit", 8'h30, 64'hFFFF_0000_0000_1234, 4, 64'hFFFF_0000_0000_0234);
      bank_val = 64'hDEAD_BEEF_1234_5678;
      rd_ok("R9 cmd read full", 8'h30, 64'hDEAD_BEEF_1234_5678);
      rd_ok("R9 ID upper cleared", 8'h02, 64'h0000_0000_1234_5678);
      bank_val = '1;
   endtask

   task automatic t_read_mask;
      rd_ok("R9 version", 8'h03, 64'h00FF_00FF);
      rd_ok("R9 spur", 8'h0F, 64'h11FF);
      rd_ok("R9 ESR", 8'h28, 64'hFF);
      rd_ok("R9 LVT", 8'h34, 64'h0003_17FF);
      rd_ok("R9 TDIV", 8'h3E, 64'hB);
   endtask

   task automatic t_enables;
      for (int i = 0; i < 6; i++) wr_ok("R11 LVT entry", 8'(8'h32 + i), 64'h10FF, 8 + i, 64'h10FF);
      wr_ok("R11 timer init", 8'h38, 64'hFFFF_FFFF, 6, 64'hFFFF_FFFF);
      wr_ok("R11 timer divide", 8'h3E, 64'h9, 7, 64'h9);
      flt("R10 LVT bad bit", 1'b1, 8'h33, 64'h0004_0000, 2'd2);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk); rst_n = 1'b1;
      t_window();
      t_mode();
      t_reserved();
      t_readonly();
      t_writeonly();
      t_zero_only();
      t_rsvd_bits();
      t_cmd();
      t_read_mask();
      t_enables();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule